// File: doc/BRIEF.md
# Serially Loaded Double-Buffered PWM Generator

This block produces a pulse-width modulated output from an 8-bit duty value that arrives serially. Bits enter on a data pin and are clocked in by a separate shift clock. A load strobe marks a completed value. The shift register's low bit is driven out again, so several units can be chained on one serial line.

A free-running period counter is compared with an active duty register. A new value does not go straight to the output. The load strobe only marks it as pending, and it is copied into the active register when the counter wraps. Every period therefore runs completely at one duty value. A duty of zero keeps the output low for the whole period, and a duty of all ones keeps it high for the whole period.

The shift clock, the serial data and the load strobe come from outside the PWM clock domain. They are resynchronised before the block uses them. Only rising edges of the synchronised shift clock and of the synchronised strobe have any effect.

Top module: `spwm_serial_pwm`

## Requirements
- R1: Each rising edge of the synchronised shift clock moves the shift register one place toward bit 0 and puts the synchronised data bit into bit 7. The first bit sent therefore ends in bit 0, so a value is sent LSB first. Reset clears the register.
- R2: The serial output always equals bit 0 of the shift register.
- R3: The period counter is 0 after reset and counts up by one on every clock, wrapping from 255 to 0. One period is 256 clocks.
- R4: For a duty below 255, the output is high while the counter is below the duty and low for the rest of the period. The output is high for exactly `duty` clocks, all at the start of the period, and a duty of 0 gives no high clocks.
- R5: A duty of 255 keeps the output high for all 256 clocks of the period.
- R6: A rising edge of the synchronised strobe sets a pending flag. On the clock where the counter goes from 255 to 0, a pending value is copied from the shift register into the active duty register and the flag is cleared. The period in progress keeps its old duty.
- R7: Holding the strobe high across several periods counts as one edge. Values shifted in while it stays high, and its falling edge, commit nothing.
- R8: If a strobe edge falls on the same clock as a commit, the pending flag stays set. The shift register contents are then committed again at the following wrap.
- R9: Reset clears the active duty and the pending flag and drives the output low. Each asynchronous input passes through two flip-flop stages before it is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | PWM clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial duty data |
| sclk_i | input | 1 | Shift clock, sampled and edge-detected |
| load_i | input | 1 | Load strobe, rising edge marks a value pending |
| sdata_o | output | 1 | Bit 0 of the shift register, for chaining |
| pwm_o | output | 1 | PWM output, registered |

## Verification
The one cycle where two functions meet is the wrap clock. On that clock a pending commit can coincide with a fresh strobe edge. The bench keeps its own period counter and drives the strobe exactly three clocks before the wrap edge, so that the synchronised edge lands on that clock. It then shifts in a different value with no further strobe. The collision is judged correct when that later value appears as a whole period after the following wrap. Periods containing a load or a held strobe are also measured, and they must still show the previous duty.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int unsigned IDX_DATA = 0;
  localparam int unsigned IDX_SCLK = 1;
  localparam int unsigned IDX_LOAD = 2;
  localparam int unsigned N_ASYNC  = 3;
  localparam int unsigned SYNC_MIN = 2;
endpackage

// File: rtl/spwm_sync.sv
module spwm_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = spwm_pkg::SYNC_MIN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[STAGES-2:0], async_i};
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spwm_edge.sv
module spwm_edge #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/spwm_shift.sv
module spwm_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] value_o,
  output logic         sdata_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {bit_i, sr_q[W-1:1]};
  end

  assign value_o = sr_q;
  assign sdata_o = sr_q[0];
endmodule

// File: rtl/spwm_gen.sv
module spwm_gen #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_rise_i,
  input  logic [W-1:0] next_duty_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] active_o,
  output logic         pending_o,
  output logic         pwm_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] active_q, active_d;
  logic         pending_q, pending_d;
  logic         pwm_q, pwm_d;
  logic         wrap;

  always_comb begin
    wrap      = (cnt_q == '1);
    cnt_d     = cnt_q + 1'b1;
    active_d  = (wrap && pending_q) ? next_duty_i : active_q;
    // a fresh edge wins over the clear at wrap
    pending_d = load_rise_i ? 1'b1 : (wrap ? 1'b0 : pending_q);
    // output computed from next state so it aligns with the counter
    pwm_d     = (&active_d) | (cnt_d < active_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      active_q  <= '0;
      pending_q <= 1'b0;
      pwm_q     <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      active_q  <= active_d;
      pending_q <= pending_d;
      pwm_q     <= pwm_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign active_o  = active_q;
  assign pending_o = pending_q;
  assign pwm_o     = pwm_q;
endmodule

// File: rtl/spwm_serial_pwm.sv
module spwm_serial_pwm #(
  parameter int unsigned DUTY_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sdata_i,
  input  logic sclk_i,
  input  logic load_i,
  output logic sdata_o,
  output logic pwm_o
);
  import spwm_pkg::*;

  logic [N_ASYNC-1:0] async_bus, sync_bus;
  logic [1:0]         rise_bus;
  logic               shift_rise, load_rise;
  logic [DUTY_W-1:0]  sr_val, cnt_val, active_val;
  logic               pending_val;

  assign async_bus[IDX_DATA] = sdata_i;
  assign async_bus[IDX_SCLK] = sclk_i;
  assign async_bus[IDX_LOAD] = load_i;

  spwm_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(async_bus),
    .sync_o (sync_bus)
  );

  spwm_edge #(.WIDTH(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i({sync_bus[IDX_LOAD], sync_bus[IDX_SCLK]}),
    .rise_o (rise_bus)
  );

  assign shift_rise = rise_bus[0];
  assign load_rise  = rise_bus[1];

  spwm_shift #(.W(DUTY_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_rise),
    .bit_i  (sync_bus[IDX_DATA]),
    .value_o(sr_val),
    .sdata_o(sdata_o)
  );

  spwm_gen #(.W(DUTY_W)) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_rise_i(load_rise),
    .next_duty_i(sr_val),
    .cnt_o      (cnt_val),
    .active_o   (active_val),
    .pending_o  (pending_val),
    .pwm_o      (pwm_o)
  );
endmodule

// File: rtl/spwm_serial_pwm_chk.sv
module spwm_serial_pwm_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         shift_rise,
  input logic         load_rise,
  input logic [W-1:0] sr,
  input logic [W-1:0] cnt,
  input logic [W-1:0] active,
  input logic         pending,
  input logic         pwm_o
);
  a_r1_shift_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_rise |=> sr[W-2:0] == $past(sr[W-1:1]));

  a_r3_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt == $past(cnt) + 1'b1);

  a_r4_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active == '0) |-> !pwm_o);

  a_r5_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active == '1) |-> pwm_o);

  a_r6_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '1 && pending) |=> active == $past(sr));

  a_r6_hold_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != '1) |=> $stable(active));

  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '1 && !load_rise) |=> !pending);

  a_r8_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '1 && load_rise) |=> pending);
endmodule

bind spwm_serial_pwm spwm_serial_pwm_chk #(.W(DUTY_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .shift_rise(shift_rise),
  .load_rise (load_rise),
  .sr        (sr_val),
  .cnt       (cnt_val),
  .active    (active_val),
  .pending   (pending_val),
  .pwm_o     (pwm_o)
);

// File: tb/tb_spwm_serial_pwm.sv
module tb_spwm_serial_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic [7:0] VEC_DUTY [NVEC] = '{8'h00, 8'h01, 8'h80, 8'hFE, 8'hFF, 8'h37};
  localparam int         VEC_HIGH [NVEC] = '{0, 1, 128, 254, 256, 55};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0, sclk = 1'b0, load = 1'b0;
  logic sdata_o, pwm_o;
  logic [7:0] mcnt;
  int n_cmp = 0, n_bad = 0;

  spwm_serial_pwm dut (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .sclk_i(sclk),
    .load_i(load), .sdata_o(sdata_o), .pwm_o(pwm_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model of the period position (R3)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mcnt <= '0;
    else        mcnt <= mcnt + 8'd1;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic align_zero();
    do @(negedge clk); while (mcnt != 8'd0);
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk);
    sdata = b;
    wait_cyc(2);
    sclk = 1'b1;
    wait_cyc(4);
    sclk = 1'b0;
    wait_cyc(3);
  endtask

  task automatic shift_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) shift_bit(v[i]);
  endtask

  task automatic pulse_load();
    @(negedge clk);
    load = 1'b1;
    wait_cyc(3);
    load = 1'b0;
    wait_cyc(3);
  endtask

  // call at the negedge where mcnt==0; ends at the negedge where mcnt==255
  task automatic measure(output int highs, output int shape_ok);
    bit seen_low = 1'b0;
    highs = 0;
    shape_ok = 1;
    for (int i = 0; i < 256; i++) begin
      if (pwm_o) begin
        highs++;
        if (seen_low) shape_ok = 0;
      end else seen_low = 1'b1;
      if (i < 255) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int h, ok, prev;
    // reset state (R9, R1)
    wait_cyc(4);
    check("R9 pwm in reset", pwm_o, 0);
    check("R1 sdata_o in reset", sdata_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    align_zero();
    measure(h, ok);
    check("R9 first period highs", h, 0);

    // shift direction: LSB first, toward bit 0 (R1, R2)
    shift_byte(8'h06);
    check("R2 sdata_o after byte", sdata_o, 0);
    shift_bit(1'b0);
    check("R1 sdata_o after 9th bit", sdata_o, 1);
    shift_bit(1'b0);
    check("R1 sdata_o after 10th bit", sdata_o, 1);
    shift_bit(1'b0);
    check("R1 sdata_o after 11th bit", sdata_o, 0);

    // table walk: load mid-period, check old period then new period
    prev = 0;
    for (int i = 0; i < NVEC; i++) begin
      align_zero();
      fork
        measure(h, ok);
        begin
          shift_byte(VEC_DUTY[i]);
          check("R2 sdata_o is bit0", sdata_o, int'(VEC_DUTY[i][0]));
          pulse_load();
        end
      join
      check("R6 period in progress keeps old duty", h, prev);
      align_zero();
      measure(h, ok);
      if (VEC_DUTY[i] == 8'hFF) check("R5 full-on highs", h, VEC_HIGH[i]);
      else                      check("R4 highs equal duty", h, VEC_HIGH[i]);
      check("R4 high then low shape", ok, 1);
      prev = VEC_HIGH[i];
    end

    // held strobe: one edge only (R7)
    align_zero();
    shift_byte(8'h40);
    @(negedge clk);
    load = 1'b1;
    align_zero();
    fork
      measure(h, ok);
      shift_byte(8'hC0);
    join
    check("R6 commit after held strobe edge", h, 64);
    align_zero();
    measure(h, ok);
    check("R7 level held commits nothing new", h, 64);
    load = 1'b0;
    align_zero();
    measure(h, ok);
    check("R7 falling edge commits nothing", h, 64);
    pulse_load();
    align_zero();
    measure(h, ok);
    check("R6 new edge commits shifted value", h, 192);

    // strobe edge on the commit clock (R8)
    align_zero();
    shift_byte(8'h20);
    pulse_load();
    do @(negedge clk); while (mcnt != 8'd253);
    load = 1'b1;
    align_zero();
    fork
      measure(h, ok);
      begin
        wait_cyc(2);
        load = 1'b0;
        shift_byte(8'hA0);
      end
    join
    check("R8 first commit at collision", h, 32);
    align_zero();
    measure(h, ok);
    check("R8 pending kept, later value committed", h, 160);

    // reset mid-run (R9, R1)
    shift_byte(8'hFF);
    check("R2 sdata_o all ones", sdata_o, 1);
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(2);
    check("R1 reset clears shift register", sdata_o, 0);
    check("R9 reset drives pwm low", pwm_o, 0);
    rst_n = 1'b1;
    align_zero();
    measure(h, ok);
    check("R9 active duty cleared", h, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule